// File: doc/BRIEF.md
# CAN Bit Timing and Synchronization Unit

This unit sits between the raw receive line of a CAN-style bus and the protocol engine. It derives time quanta from the system clock with a programmable prescaler. It splits each bit into a single sync quantum, a first phase segment and a second phase segment, and emits a one-clock strobe where each bit begins (the transmit point) and where the bit is sampled. With each sample strobe it also presents the sampled bit value.

The receive line is looked at once per quantum, and a falling edge (recessive 1 to dominant 0) between two quantum boundaries is the only event the unit reacts to. While the protocol engine reports an idle bus, such an edge restarts the bit time (hard synchronization). During a frame the edge instead stretches the first segment or trims the second one, by at most the programmed jump width. The sampled value is either the line at the sample point or the majority of three quantum samples ending there.

All configuration inputs are meant to be static between resets. The strobes are plain single-cycle pulses with no back-pressure: the protocol engine must consume them in the cycle they appear.

Top module: `can_bit_timer`

## Requirements
- R1: While reset is asserted and directly after it, sample_strobe and tx_strobe are 0 and sample_bit is 1 (recessive).
- R2: One quantum lasts presc+1 clocks. With no falling edge a bit lasts 1 + (seg1_cfg+1) + (seg2_cfg+1) quanta. tx_strobe pulses for one clock as a bit begins. sample_strobe pulses for one clock at the end of the first segment. Both appear one clock after the quantum boundary, and they never coincide.
- R3: The line is registered once and captured at every quantum boundary. A falling edge is a 1 at the previous boundary and a 0 at the current one. If bus_idle is 1 at that boundary, the bit restarts: the next quantum is the first of segment one, tx_strobe pulses, and the next sample strobe comes exactly (seg1_cfg+1)*(presc+1) clocks after that tx_strobe.
- R4: A falling edge that ends quantum number p (1-based) of segment one lengthens segment one by min(p, jump_cfg+1) quanta.
- R5: A falling edge that ends a segment-two quantum with r quanta of segment two still to go restarts the bit when r+1 <= jump_cfg+1: the next quantum is the first of segment one and tx_strobe pulses. Otherwise segment two is shortened by jump_cfg+1 quanta, and the bit ends at once if nothing remains.
- R6: At most one resynchronization (R4 or R5) happens between two sample strobes. A falling edge that ends the sync quantum has no effect.
- R7: Rising edges of rx never change the bit timing.
- R8: With triple_sample at 1, sample_bit is the majority of the line values captured at the last three quantum boundaries up to and including the sample point.
- R9: With triple_sample at 0, sample_bit equals rx as it was two clocks before the sample strobe. sample_bit only changes with a sample strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc | input | 6 | Quantum length minus one, in clocks |
| seg1_cfg | input | 4 | Segment one length minus one, in quanta |
| seg2_cfg | input | 3 | Segment two length minus one, in quanta |
| jump_cfg | input | 2 | Resynchronization jump width minus one |
| triple_sample | input | 1 | 1 selects majority-of-three sampling |
| bus_idle | input | 1 | From the protocol engine: bus idle, hard sync allowed |
| rx | input | 1 | Raw receive line, 0 dominant |
| sample_strobe | output | 1 | One-clock pulse at the sample point |
| sample_bit | output | 1 | Sampled bit, valid with sample_strobe and held after it |
| tx_strobe | output | 1 | One-clock pulse where a bit begins |

## Verification
A steady recessive line checks the nominal quantum and bit lengths for two configurations. A start-of-frame edge on an idle bus checks that hard sync restarts the bit, not resynchronizes it. Transmitters running slower and faster than the nominal bit rate drive the timing into segment-one stretching on one side and segment-two trimming or restart on the other. Random glitch trains with gaps of a few clocks reach edges in the sync quantum, repeated edges within one sample interval, and single-quantum spikes at the sample point, which tell majority sampling from single sampling. A lone rising edge placed inside segment one checks that it leaves the bit length at its nominal value.

// File: rtl/can_btl_pkg.sv
package can_btl_pkg;

  // Number of quantum samples voted on in triple-sample mode.
  localparam int MAJ_TAPS = 3;

  typedef enum logic [1:0] {
    PH_SYNC = 2'd0,
    PH_SEG1 = 2'd1,
    PH_SEG2 = 2'd2
  } phase_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/btl_prescaler.sv
module btl_prescaler #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] div,
  output logic         tick
);

  logic [W-1:0] cnt;

  assign tick = (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (tick) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/btl_rx_sampler.sv
module btl_rx_sampler
  import can_btl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx,
  output logic line_now,
  output logic line_maj,
  output logic fall_edge
);

  localparam int HW = MAJ_TAPS - 1;

  logic          rx_r;
  logic [HW-1:0] hist;   // hist[0] is the previous quantum sample

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_r <= 1'b1;
      hist <= '1;
    end else begin
      rx_r <= rx;
      if (tick) hist <= {hist[HW-2:0], rx_r};
    end
  end

  assign line_now  = rx_r;
  assign line_maj  = maj3(hist[1], hist[0], rx_r);
  assign fall_edge = tick & hist[0] & ~rx_r;

endmodule

// File: rtl/btl_phase_ctrl.sv
module btl_phase_ctrl
  import can_btl_pkg::*;
#(
  parameter int SEG1_W = 4,
  parameter int SEG2_W = 3,
  parameter int SJW_W  = 2,
  parameter int CW     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              fall_edge,
  input  logic              bus_idle,
  input  logic              triple_sample,
  input  logic              line_now,
  input  logic              line_maj,
  input  logic [SEG1_W-1:0] seg1_cfg,
  input  logic [SEG2_W-1:0] seg2_cfg,
  input  logic [SJW_W-1:0]  jump_cfg,
  output logic              sample_strobe,
  output logic              sample_bit,
  output logic              tx_strobe
);

  phase_t        phase, n_phase;
  logic [CW-1:0] qidx, n_qidx;    // 1-based quantum index inside the segment
  logic [CW-1:0] lim1, n_lim1;    // current end of segment one
  logic [CW-1:0] lim2, n_lim2;    // current end of segment two
  logic          resynced, n_res;
  logic          n_samp, n_bit, n_tx;
  logic [CW-1:0] ext, rem;
  logic [CW-1:0] t1, t2, sjw_q;

  assign t1    = CW'(seg1_cfg) + CW'(1);
  assign t2    = CW'(seg2_cfg) + CW'(1);
  assign sjw_q = CW'(jump_cfg) + CW'(1);

  always_comb begin
    n_phase = phase;
    n_qidx  = qidx;
    n_lim1  = lim1;
    n_lim2  = lim2;
    n_res   = resynced;
    n_samp  = 1'b0;
    n_tx    = 1'b0;
    n_bit   = sample_bit;
    ext     = '0;
    rem     = '0;
    if (tick) begin
      if (fall_edge && bus_idle) begin
        n_phase = PH_SEG1;
        n_qidx  = CW'(1);
        n_lim1  = t1;
        n_res   = 1'b0;
        n_tx    = 1'b1;
      end else begin
        case (phase)
          PH_SYNC: begin
            n_phase = PH_SEG1;
            n_qidx  = CW'(1);
            n_lim1  = t1;
          end
          PH_SEG1: begin
            if (fall_edge && !resynced) begin
              ext   = (qidx < sjw_q) ? qidx : sjw_q;
              n_res = 1'b1;
            end
            if (qidx >= lim1 + ext) begin
              n_samp  = 1'b1;
              n_bit   = triple_sample ? line_maj : line_now;
              n_phase = PH_SEG2;
              n_qidx  = CW'(1);
              n_lim2  = t2;
              n_res   = 1'b0;
            end else begin
              n_qidx = qidx + CW'(1);
              n_lim1 = lim1 + ext;
            end
          end
          PH_SEG2: begin
            rem = lim2 - qidx;
            if (fall_edge && !resynced) begin
              n_res = 1'b1;
              if (rem < sjw_q) begin
                n_phase = PH_SEG1;
                n_qidx  = CW'(1);
                n_lim1  = t1;
                n_tx    = 1'b1;
              end else if (rem == sjw_q) begin
                n_phase = PH_SYNC;
                n_tx    = 1'b1;
              end else begin
                n_lim2 = lim2 - sjw_q;
                n_qidx = qidx + CW'(1);
              end
            end else if (qidx >= lim2) begin
              n_phase = PH_SYNC;
              n_tx    = 1'b1;
            end else begin
              n_qidx = qidx + CW'(1);
            end
          end
          default: n_phase = PH_SYNC;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase         <= PH_SYNC;
      qidx          <= '0;
      lim1          <= '0;
      lim2          <= '0;
      resynced      <= 1'b0;
      sample_strobe <= 1'b0;
      sample_bit    <= 1'b1;
      tx_strobe     <= 1'b0;
    end else begin
      phase         <= n_phase;
      qidx          <= n_qidx;
      lim1          <= n_lim1;
      lim2          <= n_lim2;
      resynced      <= n_res;
      sample_strobe <= n_samp;
      sample_bit    <= n_bit;
      tx_strobe     <= n_tx;
    end
  end

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_btl_pkg::*;
#(
  parameter int PRESC_W = 6,
  parameter int SEG1_W  = 4,
  parameter int SEG2_W  = 3,
  parameter int SJW_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PRESC_W-1:0] presc,
  input  logic [SEG1_W-1:0]  seg1_cfg,
  input  logic [SEG2_W-1:0]  seg2_cfg,
  input  logic [SJW_W-1:0]   jump_cfg,
  input  logic               triple_sample,
  input  logic               bus_idle,
  input  logic               rx,
  output logic               sample_strobe,
  output logic               sample_bit,
  output logic               tx_strobe
);

  localparam int W12    = (SEG1_W > SEG2_W) ? SEG1_W : SEG2_W;
  localparam int WIDEST = (W12 > SJW_W) ? W12 : SJW_W;
  localparam int CW     = WIDEST + 2;

  logic tq_tick;
  logic line_now;
  logic line_maj;
  logic fall_edge;

  btl_prescaler #(.W(PRESC_W)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .div  (presc),
    .tick (tq_tick)
  );

  btl_rx_sampler u_rxs (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tq_tick),
    .rx       (rx),
    .line_now (line_now),
    .line_maj (line_maj),
    .fall_edge(fall_edge)
  );

  btl_phase_ctrl #(
    .SEG1_W(SEG1_W),
    .SEG2_W(SEG2_W),
    .SJW_W (SJW_W),
    .CW    (CW)
  ) u_phase (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tq_tick),
    .fall_edge    (fall_edge),
    .bus_idle     (bus_idle),
    .triple_sample(triple_sample),
    .line_now     (line_now),
    .line_maj     (line_maj),
    .seg1_cfg     (seg1_cfg),
    .seg2_cfg     (seg2_cfg),
    .jump_cfg     (jump_cfg),
    .sample_strobe(sample_strobe),
    .sample_bit   (sample_bit),
    .tx_strobe    (tx_strobe)
  );

endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic triple_sample,
  input logic rx,
  input logic sample_strobe,
  input logic sample_bit,
  input logic tx_strobe
);

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_strobe && tx_strobe));

  // R2
  strobe_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |-> $past(tick));

  // R2
  sample_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |=> !sample_strobe);

  // R9
  single_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_strobe && !triple_sample) |-> (sample_bit == $past(rx, 2)));

  // R9
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_strobe |-> $stable(sample_bit));

endmodule

bind can_bit_timer can_bit_timer_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick         (tq_tick),
  .triple_sample(triple_sample),
  .rx           (rx),
  .sample_strobe(sample_strobe),
  .sample_bit   (sample_bit),
  .tx_strobe    (tx_strobe)
);

// File: tb/can_bit_timer_test.sv
module can_bit_timer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] presc = 6'd1;
  logic [3:0] seg1_cfg = 4'd5;
  logic [2:0] seg2_cfg = 3'd2;
  logic [1:0] jump_cfg = 2'd1;
  logic       triple_sample = 1'b0;
  logic       bus_idle = 1'b0;
  logic       rx = 1'b1;
  wire        samp, sbit, txs;

  always #5 clk = ~clk;

  can_bit_timer uut (
    .clk(clk), .rst_n(rst_n), .presc(presc), .seg1_cfg(seg1_cfg),
    .seg2_cfg(seg2_cfg), .jump_cfg(jump_cfg), .triple_sample(triple_sample),
    .bus_idle(bus_idle), .rx(rx), .sample_strobe(samp), .sample_bit(sbit),
    .tx_strobe(txs)
  );

  int    checks = 0;
  int    fails = 0;
  string req = "R1";
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;
  bit [31:0] seed = 32'h1234_5678;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: position within the bit counted in quanta from the sync quantum.
  int m_pc = 0;
  bit m_rxr = 1, m_last = 1, m_prev2 = 1;
  int bq = 0, s1end = 0, bend = 0;
  bit res = 0;
  bit e_samp = 0, e_bit = 1, e_tx = 0;

  always @(posedge clk) begin : model
    int t1, t2, sj, r, ext;
    bit tk, edg, maj;
    if (!rst_n) begin
      m_pc = 0; m_rxr = 1; m_last = 1; m_prev2 = 1;
      bq = 0; s1end = 0; bend = 0; res = 0;
      e_samp = 0; e_bit = 1; e_tx = 0;
    end else begin
      t1 = seg1_cfg + 1;
      t2 = seg2_cfg + 1;
      sj = jump_cfg + 1;
      tk = (m_pc == presc);
      m_pc = tk ? 0 : m_pc + 1;
      e_samp = 0;
      e_tx = 0;
      if (tk) begin
        edg = m_last && !m_rxr;
        maj = (int'(m_prev2) + int'(m_last) + int'(m_rxr)) >= 2;
        if (edg && bus_idle) begin
          bq = 1; s1end = t1; bend = t1 + t2; res = 0; e_tx = 1;
        end else if (bq == 0) begin
          bq = 1; s1end = t1; bend = t1 + t2;
        end else if (bq <= s1end) begin
          if (edg && !res) begin
            ext = (bq < sj) ? bq : sj;
            s1end += ext; bend += ext; res = 1;
          end
          if (bq == s1end) begin
            e_samp = 1;
            e_bit = triple_sample ? maj : m_rxr;
            res = 0;
          end
          bq++;
        end else begin
          r = bend - bq;
          if (edg && !res) begin
            res = 1;
            if (r + 1 <= sj) begin
              bq = 1; s1end = t1; bend = t1 + t2; e_tx = 1;
            end else begin
              bend -= sj;
              if (bend == bq) begin bq = 0; e_tx = 1; end
              else bq++;
            end
          end else if (bq == bend) begin
            bq = 0; e_tx = 1;
          end else bq++;
        end
        m_prev2 = m_last;
        m_last = m_rxr;
      end
      m_rxr = rx;
    end
  end

  // Per-clock comparison against the reference.
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      check({req, " sample_strobe"}, samp, e_samp);
      check({req, " tx_strobe"}, txs, e_tx);
      check({req, " sample_bit"}, sbit, e_bit);
    end
  end

  // Strobe spacing monitor.
  int cyc = 0, last_tx = 0, gap_tx = 0, tx2s = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n && txs) begin gap_tx = cyc - last_tx; last_tx = cyc; end
    if (rst_n && samp) tx2s = cyc - last_tx;
  end

  task automatic step(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wait_tx();
    do step(1); while (!txs);
  endtask

  task automatic wait_samp();
    do step(1); while (!samp);
  endtask

  function automatic bit rnd_bit();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed[20];
  endfunction

  function automatic int rnd_gap(input int maxg);
    seed = seed * 32'd1664525 + 32'd1013904223;
    return int'(seed[15:8]) % maxg + 1;
  endfunction

  task automatic do_reset();
    cmp_on = 0;
    rst_n = 0;
    rx = 1;
    bus_idle = 0;
    step(3);
    check("R1 sample_strobe in reset", samp, 0);
    check("R1 tx_strobe in reset", txs, 0);
    check("R1 sample_bit in reset", sbit, 1);
    rst_n = 1;
    cmp_on = 1;
    step(1);
    check("R1 sample_bit after reset", sbit, 1);
  endtask

  task automatic send_frame(input int nbits, input int period);
    bus_idle = 1;
    rx = 1;
    step(7);
    for (int i = 0; i < nbits; i++) begin
      rx = (i == 0) ? 1'b0 : rnd_bit();
      if (i == 1) bus_idle = 0;
      step(period);
    end
    rx = 1;
    step(3 * period);
    bus_idle = 1;
    step(period);
  endtask

  task automatic run_random(input int ncyc, input int maxg, input bit toggle_idle);
    int used = 0;
    while (used < ncyc) begin
      int g = rnd_gap(maxg);
      rx = rnd_bit();
      if (toggle_idle) bus_idle = rnd_bit() & rnd_bit();
      step(g);
      used += g;
    end
    bus_idle = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    // Config A: 2-clock quanta, 6+3 segment quanta, jump 2.
    presc = 6'd1; seg1_cfg = 4'd5; seg2_cfg = 3'd2; jump_cfg = 2'd1; triple_sample = 0;
    do_reset();

    req = "R2 R9";
    step(200);
    check("R2 nominal bit length A", gap_tx, 20);

    req = "R3";
    bus_idle = 1;
    step(7);
    rx = 0;
    wait_samp();
    check("R3 tx to sample after hard sync", tx2s, 12);
    bus_idle = 0;
    step(60);

    req = "R4";
    send_frame(40, 22);
    req = "R5";
    send_frame(40, 18);

    // R7: a rising edge inside segment one leaves the bit length alone.
    do_reset();
    req = "R7";
    step(50);
    rx = 0;
    step(60);
    wait_tx();
    step(9);
    rx = 1;
    wait_tx();
    check("R7 bit length across rising edge", gap_tx, 20);
    wait_tx();
    check("R7 following bit length", gap_tx, 20);

    // Config C: 1-clock quanta, triple sampling, glitch trains.
    presc = 6'd0; seg1_cfg = 4'd7; seg2_cfg = 3'd3; jump_cfg = 2'd2; triple_sample = 1;
    do_reset();
    req = "R4 R5 R6 R8";
    run_random(4000, 6, 0);
    req = "R3 R6 R8";
    run_random(2000, 9, 1);

    triple_sample = 0;
    do_reset();
    req = "R4 R5 R6 R9";
    run_random(4000, 6, 0);

    // Config B: 4-clock quanta, longest segments, widest jump.
    presc = 6'd3; seg1_cfg = 4'd15; seg2_cfg = 3'd7; jump_cfg = 2'd3; triple_sample = 0;
    do_reset();
    req = "R2";
    step(400);
    check("R2 nominal bit length B", gap_tx, 100);
    req = "R4";
    send_frame(30, 104);
    req = "R5";
    send_frame(30, 96);
    req = "R6 R7";
    run_random(6000, 40, 0);

    triple_sample = 1;
    do_reset();
    req = "R3 R6 R8";
    run_random(6000, 30, 1);

    cmp_on = 0;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule